// File: doc/BRIEF.md
# Serial Memory Target Protocol Engine

This block is the two-wire bus front end of a byte-addressed serial memory. A fast system clock oversamples the SCL and SDA lines. The block frames the bus conditions and takes in the device-select byte and a two-byte location. It then handles data bytes in both directions.

The block does not own the memory array or the page buffer. Those sit behind a set of single-cycle strobes: load a new location, write one byte, consume one read byte, and commit the buffered bytes. A busy input comes back from the back end. The SDA line is open drain, so the block only ever asserts a pull-low enable.

The block supports three strapped select pins. It samples the write-protect input once per write. While the back end is busy, the block does not answer, so a bus master can poll the device until the internal write completes.

Top module: `i2c_mem_target`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts device-byte reception from any state and releases SDA. Data bytes taken before that START are dropped: a later STOP does not commit them.
- R2: In the device byte, bits 7:4 must equal 4'b1010 and bits 3:1 must equal `dev_sel[2:0]`. Bit 0 selects the direction, with 1 meaning read, and bits arrive MSB first. On a mismatch the block gives no ACK and ignores the bus until the next START.
- R3: The block acknowledges by holding `sda_oe` high through the 9th SCL clock. It does this for a matching device byte, for both location bytes and for each accepted write byte. Out of reset, `sda_oe` is low.
- R4: `sda_oe` changes only while SCL is low. The block samples input bits on rising SCL and moves its output after falling SCL.
- R5: While `be_busy` is high, the device byte is not acknowledged, whichever direction it requests.
- R6: A write transfer carries two location bytes, high byte first. The two top bits of the high byte are ignored. Once the low byte completes, `be_load` pulses once with the 14-bit location on `be_addr`.
- R7: `wr_protect` is sampled only on the falling SCL edge that ends the second location byte's ACK. If it was high, the first data byte gets no ACK, and no `be_wr` or `be_commit` follows. A change of `wr_protect` after that point has no effect on the transfer.
- R8: Each accepted data byte produces one `be_wr` pulse, with that byte on `be_wdata`. At most one back-end strobe is high in any cycle.
- R9: A STOP after at least one accepted data byte pulses `be_commit` once. A STOP after only the location bytes sets the location and commits nothing.
- R10: A read takes the byte at the back end's current location, pulsing `be_rd` for each byte fetched. It streams further bytes while the master ACKs. After a NoACK it releases SDA and goes idle.
- R11: A location write followed by a repeated START and a read device byte returns the data at the newly loaded location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| dev_sel | input | 3 | Strapped device-select value |
| wr_protect | input | 1 | 1 blocks writes for the next transfer |
| be_busy | input | 1 | Back end is in its internal write cycle |
| be_rdata | input | 8 | Byte at the back end's current location |
| be_load | output | 1 | Pulse: load `be_addr` into the location counter |
| be_addr | output | 14 | Location carried with `be_load` |
| be_wr | output | 1 | Pulse: write `be_wdata` at the location, then advance |
| be_wdata | output | 8 | Write data carried with `be_wr` |
| be_rd | output | 1 | Pulse: `be_rdata` consumed, advance the location |
| be_commit | output | 1 | Pulse: start the internal write cycle |

## Verification
Every result of this block depends on the SCL timing, not on a fixed clock count. The input path adds about five system clocks: two synchroniser stages, a three-sample majority window and one edge register. The ACK or data bit therefore appears on `sda_oe` that many cycles after the SCL fall that ends a bit. The bench holds each SCL phase for 12 to 24 system clocks and samples SDA in the middle of SCL high, so the result is long settled. Back-end strobes are counted as they happen and compared only once the following SCL phase has begun.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial memory target engine.
// Assumes: consumed by the engine FSM only.
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

    typedef enum logic [1:0] {
        BK_DEV,
        BK_AHI,
        BK_ALO,
        BK_DATA
    } byte_kind_e;
endpackage

// File: rtl/i2c_line_filter.sv
`timescale 1ns/1ps
// Synchronises one bus line into clk and removes short spikes.
// It uses a majority vote over a window of FILT_LEN samples.
// Assumes: the line idles high; SYNC_STAGES >= 2, FILT_LEN >= 2.
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    win_q;
    logic [CNT_W-1:0]       ones;
    logic                   out_q;

    // Synchroniser chain and sample window shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    // Count the high samples in the window.
    always_comb begin
        ones = '0;
        for (int i = 0; i < FILT_LEN; i++) begin
            ones = ones + CNT_W'(win_q[i]);
        end
    end

    // Register the majority decision.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b1;
        else        out_q <= (ones > CNT_W'(FILT_LEN / 2));
    end

    assign line_out = out_q;
endmodule

// File: rtl/i2c_cond_detect.sv
`timescale 1ns/1ps
// Derives SCL edges and the START and STOP bus conditions from filtered lines.
// Assumes: the inputs are already synchronous to clk and free of glitches.
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Hold the previous line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_tgt_fsm.sv
`timescale 1ns/1ps
// Byte-level protocol engine. It shifts bits in on rising SCL and moves its
// SDA drive after falling SCL. It decodes the device byte and two location
// bytes, then streams write or read bytes through back-end strobes.
// Assumes: edge and condition pulses are one clk wide and come from filtered
// lines; be_rdata always shows the byte at the back end's current location.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int         ADDR_W   = 14,
    parameter logic [3:0] DEV_TYPE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_f,
    input  logic [2:0]        dev_sel,
    input  logic              wr_protect,
    input  logic              be_busy,
    input  logic [7:0]        be_rdata,
    output logic              sda_oe,
    output logic              be_load,
    output logic [ADDR_W-1:0] be_addr,
    output logic              be_wr,
    output logic [7:0]        be_wdata,
    output logic              be_rd,
    output logic              be_commit
);
    tgt_state_e  state;
    byte_kind_e  kind;
    logic [3:0]  bit_cnt;
    logic [7:0]  shreg;
    logic [7:0]  addr_hi;
    logic        rw_q;
    logic        wp_q;
    logic        data_seen;
    logic        m_ack;

    logic dev_match;
    assign dev_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == dev_sel) && !be_busy;

    // Main protocol sequencer; all outputs are registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= BK_DEV;
            bit_cnt   <= '0;
            shreg     <= '0;
            addr_hi   <= '0;
            rw_q      <= 1'b0;
            wp_q      <= 1'b0;
            data_seen <= 1'b0;
            m_ack     <= 1'b0;
            sda_oe    <= 1'b0;
            be_load   <= 1'b0;
            be_addr   <= '0;
            be_wr     <= 1'b0;
            be_wdata  <= '0;
            be_rd     <= 1'b0;
            be_commit <= 1'b0;
        end else begin
            be_load   <= 1'b0;
            be_wr     <= 1'b0;
            be_rd     <= 1'b0;
            be_commit <= 1'b0;
            if (start_det) begin
                state     <= ST_RX;
                kind      <= BK_DEV;
                bit_cnt   <= '0;
                sda_oe    <= 1'b0;
                data_seen <= 1'b0;
            end else if (stop_det) begin
                state     <= ST_IDLE;
                sda_oe    <= 1'b0;
                be_commit <= data_seen;
                data_seen <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_f};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            case (kind)
                                BK_DEV: begin
                                    if (dev_match) begin
                                        rw_q   <= shreg[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_RX_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                BK_AHI: begin
                                    addr_hi <= shreg;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_RX_ACK;
                                end
                                BK_ALO: begin
                                    be_load <= 1'b1;
                                    be_addr <= ADDR_W'({addr_hi, shreg});
                                    sda_oe  <= 1'b1;
                                    state   <= ST_RX_ACK;
                                end
                                default: begin
                                    if (wp_q) begin
                                        state <= ST_IDLE;
                                    end else begin
                                        be_wr     <= 1'b1;
                                        be_wdata  <= shreg;
                                        data_seen <= 1'b1;
                                        sda_oe    <= 1'b1;
                                        state     <= ST_RX_ACK;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                            case (kind)
                                BK_DEV: begin
                                    if (rw_q) begin
                                        shreg  <= be_rdata;
                                        be_rd  <= 1'b1;
                                        sda_oe <= ~be_rdata[7];
                                        state  <= ST_TX;
                                    end else begin
                                        kind <= BK_AHI;
                                    end
                                end
                                BK_AHI:  kind <= BK_ALO;
                                BK_ALO: begin
                                    kind <= BK_DATA;
                                    wp_q <= wr_protect;
                                end
                                default: kind <= BK_DATA;
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                bit_cnt <= '0;
                                sda_oe  <= 1'b0;
                                state   <= ST_TX_ACK;
                            end else begin
                                bit_cnt <= bit_cnt + 4'd1;
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_oe  <= ~shreg[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_f;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                shreg  <= be_rdata;
                                be_rd  <= 1'b1;
                                sda_oe <= ~be_rdata[7];
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_mem_target.sv
`timescale 1ns/1ps
// Top of the serial memory target. It filters both bus lines, detects bus
// conditions and runs the protocol engine towards a memory back end.
// Assumes: clk is at least about 20x the SCL rate; the SDA pad is driven low
// externally whenever sda_oe is high.
module i2c_mem_target #(
    parameter int         ADDR_W      = 14,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [2:0]        dev_sel,
    input  logic              wr_protect,
    input  logic              be_busy,
    input  logic [7:0]        be_rdata,
    output logic              be_load,
    output logic [ADDR_W-1:0] be_addr,
    output logic              be_wr,
    output logic [7:0]        be_wdata,
    output logic              be_rd,
    output logic              be_commit
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] flt_lines;
    logic scl_flt, sda_flt;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {scl_in, sda_in};

    // One synchroniser and spike filter per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (raw_lines[g]),
            .line_out(flt_lines[g])
        );
    end

    assign scl_flt = flt_lines[1];
    assign sda_flt = flt_lines[0];

    i2c_cond_detect u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_flt),
        .sda_f    (sda_flt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_tgt_fsm #(
        .ADDR_W  (ADDR_W),
        .DEV_TYPE(DEV_TYPE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_f     (sda_flt),
        .dev_sel   (dev_sel),
        .wr_protect(wr_protect),
        .be_busy   (be_busy),
        .be_rdata  (be_rdata),
        .sda_oe    (sda_oe),
        .be_load   (be_load),
        .be_addr   (be_addr),
        .be_wr     (be_wr),
        .be_wdata  (be_wdata),
        .be_rd     (be_rd),
        .be_commit (be_commit)
    );
endmodule

// File: rtl/i2c_mem_target_chk.sv
`timescale 1ns/1ps
// Property checker for the serial memory target; attached by bind below.
// Assumes: observes the filtered SCL and the condition pulses inside the top.
module i2c_mem_target_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_f,
    input logic start_det,
    input logic stop_det,
    input logic be_load,
    input logic be_wr,
    input logic be_rd,
    input logic be_commit
);
    // R8: back-end strobes never overlap.
    a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({be_load, be_wr, be_rd, be_commit}));

    // R9: a commit is only ever the response to a STOP.
    a_r9_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        be_commit |-> $past(stop_det));

    // R1: a START leaves SDA released.
    a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R4: the SDA drive holds while SCL stays high.
    a_r4_oe_holds_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R10: a read fetch is never a write or a commit.
    a_r10_rd_not_wr: assert property (@(posedge clk) disable iff (!rst_n)
        be_rd |-> (!be_wr && !be_commit));
endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_f    (scl_flt),
    .start_det(start_det),
    .stop_det (stop_det),
    .be_load  (be_load),
    .be_wr    (be_wr),
    .be_rd    (be_rd),
    .be_commit(be_commit)
);

// File: tb/i2c_mem_target_bench.sv
`timescale 1ns/1ps
module i2c_mem_target_bench;
    localparam int Q = 12;          // quarter SCL period in clk cycles
    localparam int BUSY_CYC = 2000;
    localparam int N_VEC = 8;
    // {device byte, dev_sel strap, expected ACK}
    localparam logic [11:0] DEV_VEC [N_VEC] = '{
        {8'hA0, 3'd0, 1'b1},
        {8'hA2, 3'd0, 1'b0},
        {8'hA2, 3'd1, 1'b1},
        {8'hAE, 3'd7, 1'b1},
        {8'hAC, 3'd7, 1'b0},
        {8'hB0, 3'd0, 1'b0},
        {8'h20, 3'd0, 1'b0},
        {8'hAC, 3'd6, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [2:0] dev_sel = 3'd0;
    logic wr_protect = 1'b0;
    logic be_busy;
    logic [7:0] be_rdata;
    logic be_load, be_wr, be_rd, be_commit;
    logic [13:0] be_addr;
    logic [7:0] be_wdata;

    int n_chk = 0, n_fail = 0;
    int n_load = 0, n_wr = 0, n_rd = 0, n_commit = 0, oe_bad = 0;
    int busy_cnt = 0;
    logic [13:0] last_addr = '0;
    logic [7:0] last_wdata = '0;
    logic [13:0] cnt = '0;
    logic [7:0] mem [256];
    logic oe_prev = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_mem_target u_i2c_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .dev_sel(dev_sel), .wr_protect(wr_protect), .be_busy(be_busy),
        .be_rdata(be_rdata), .be_load(be_load), .be_addr(be_addr), .be_wr(be_wr),
        .be_wdata(be_wdata), .be_rd(be_rd), .be_commit(be_commit)
    );

    // Back-end model: location counter, byte store and busy timer.
    always @(posedge clk) begin
        if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
        if (be_load) begin n_load++; last_addr = be_addr; cnt = be_addr; end
        if (be_wr) begin n_wr++; last_wdata = be_wdata; mem[cnt[7:0]] = be_wdata; cnt = cnt + 14'd1; end
        if (be_rd) begin n_rd++; cnt = cnt + 14'd1; end
        if (be_commit) begin n_commit++; busy_cnt = BUSY_CYC; end
        if (rst_n && (sda_oe != oe_prev) && scl) oe_bad++;
        oe_prev = sda_oe;
    end
    assign be_busy = (busy_cnt != 0);
    always_comb be_rdata = mem[cnt[7:0]];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_n(Q); scl = 1'b1; wait_n(2*Q);
        sda_m = 1'b0; wait_n(2*Q); scl = 1'b0; wait_n(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_n(Q); scl = 1'b1; wait_n(2*Q);
        sda_m = 1'b1; wait_n(2*Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wait_n(Q); scl = 1'b1; wait_n(2*Q); scl = 1'b0; wait_n(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wait_n(Q); scl = 1'b1; wait_n(Q); b = sda_bus;
        wait_n(Q); scl = 1'b0; wait_n(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(x);
        ack = ~x;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) begin bit_in(x); d[i] = x; end
        bit_out(give_ack ? 1'b0 : 1'b1);
    endtask

    task automatic wait_idle();
        while (be_busy) wait_n(1);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int b_load, b_wr, b_commit, b_rd;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
        wait_n(10);
        check("R3 reset sda_oe", 32'(sda_oe), 0);
        rst_n = 1'b1;
        wait_n(20);
        check("R3 idle sda_oe", 32'(sda_oe), 0);
        check("R8 no strobes after reset", 32'(n_load + n_wr + n_rd + n_commit), 0);

        // R2: device byte decoding over the vector table
        for (int v = 0; v < N_VEC; v++) begin
            dev_sel = DEV_VEC[v][3:1];
            wait_n(4);
            bus_start();
            send_byte(DEV_VEC[v][11:4], ack);
            check($sformatf("R2 vec%0d ack", v), 32'(ack), 32'(DEV_VEC[v][0]));
            bus_stop();
        end
        dev_sel = 3'd0;
        check("R9 no commit from bare device bytes", 32'(n_commit), 0);

        // Byte write
        b_load = n_load;
        bus_start();
        send_byte(8'hA0, ack); check("R3 dev ack", 32'(ack), 1);
        send_byte(8'h01, ack); check("R3 hi ack", 32'(ack), 1);
        send_byte(8'h23, ack); check("R3 lo ack", 32'(ack), 1);
        check("R6 one load", 32'(n_load - b_load), 1);
        check("R6 location", 32'(last_addr), 32'h0123);
        b_wr = n_wr;
        send_byte(8'h5A, ack); check("R3 data ack", 32'(ack), 1);
        check("R8 one write", 32'(n_wr - b_wr), 1);
        check("R8 write data", 32'(last_wdata), 32'h5A);
        b_commit = n_commit;
        bus_stop(); wait_n(4);
        check("R9 commit", 32'(n_commit - b_commit), 1);

        // R5: no answer while busy
        bus_start(); send_byte(8'hA0, ack); check("R5 busy write nack", 32'(ack), 0); bus_stop();
        bus_start(); send_byte(8'hA1, ack); check("R5 busy read nack", 32'(ack), 0); bus_stop();
        wait_idle();

        // R6 top bits ignored, R11 selective read back of the written byte
        b_commit = n_commit;
        bus_start();
        send_byte(8'hA0, ack); send_byte(8'hC1, ack); send_byte(8'h23, ack);
        check("R6 top bits ignored", 32'(last_addr), 32'h0123);
        bus_start();
        send_byte(8'hA1, ack); check("R11 read dev ack", 32'(ack), 1);
        recv_byte(1'b0, d); check("R11 selective data", 32'(d), 32'h5A);
        bus_stop(); wait_n(4);
        check("R9 no commit without data", 32'(n_commit - b_commit), 0);

        // R7: write protect blocks the first data byte
        wr_protect = 1'b1;
        b_wr = n_wr; b_commit = n_commit;
        bus_start();
        send_byte(8'hA0, ack); send_byte(8'h00, ack); send_byte(8'h10, ack);
        send_byte(8'h77, ack); check("R7 protected nack", 32'(ack), 0);
        bus_stop(); wait_n(4);
        check("R7 no write", 32'(n_wr - b_wr), 0);
        check("R7 no commit", 32'(n_commit - b_commit), 0);

        // R7: protect sampled once; raising it later has no effect
        wr_protect = 1'b0;
        b_wr = n_wr; b_commit = n_commit;
        bus_start();
        send_byte(8'hA0, ack); send_byte(8'h00, ack); send_byte(8'h30, ack);
        send_byte(8'h11, ack); check("R7 first byte ack", 32'(ack), 1);
        wr_protect = 1'b1;
        send_byte(8'h22, ack); check("R7 late protect ignored", 32'(ack), 1);
        bus_stop(); wait_n(4);
        check("R8 two writes", 32'(n_wr - b_wr), 2);
        check("R9 page commit", 32'(n_commit - b_commit), 1);
        wr_protect = 1'b0;
        wait_idle();

        // R9: location-only write, then R10 immediate read
        b_load = n_load; b_commit = n_commit;
        bus_start();
        send_byte(8'hA0, ack); send_byte(8'h00, ack); send_byte(8'h40, ack);
        bus_stop(); wait_n(4);
        check("R9 location set", 32'(n_load - b_load), 1);
        check("R9 no commit after location only", 32'(n_commit - b_commit), 0);
        b_rd = n_rd;
        bus_start();
        send_byte(8'hA1, ack); check("R10 read ack", 32'(ack), 1);
        recv_byte(1'b0, d); check("R10 immediate data", 32'(d), 32'h7C);
        check("R10 one fetch", 32'(n_rd - b_rd), 1);
        wait_n(Q);
        check("R10 released after nack", 32'(sda_oe), 0);
        bus_stop();

        // R10/R11 sequential read from a loaded location
        bus_start();
        send_byte(8'hA0, ack); send_byte(8'h00, ack); send_byte(8'h10, ack);
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b1, d); check("R11 seq byte0", 32'(d), 32'h2C);
        recv_byte(1'b1, d); check("R10 seq byte1", 32'(d), 32'h2D);
        recv_byte(1'b0, d); check("R10 seq byte2", 32'(d), 32'h2E);
        bus_stop();

        // R1: START mid-write drops the pending data
        b_commit = n_commit;
        bus_start();
        send_byte(8'hA0, ack); send_byte(8'h00, ack); send_byte(8'h50, ack);
        send_byte(8'h99, ack); check("R1 data accepted", 32'(ack), 1);
        bus_start();
        send_byte(8'hA0, ack); check("R1 restart dev ack", 32'(ack), 1);
        bus_stop(); wait_n(4);
        check("R1 aborted no commit", 32'(n_commit - b_commit), 0);
        check("R1 released", 32'(sda_oe), 0);

        check("R4 sda_oe moved only with SCL low", 32'(oe_bad), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule